// File: doc/BRIEF.md
# Keyed Write Guard for Protected Control Registers

This block sits on a simple register bus in front of a small register file. The bus has an address, a write strobe, a read strobe and write data. Two of the registers are protected: an output-control word and a fault-control word. The other registers are ordinary: a period word, a phase word and a status word.

While protection is enabled, software must first write a two-word key to a dedicated key address. The protected write must then be the very next bus access. Each unlock admits exactly one protected write. Any other access cancels the unlock.

A read-modify-write is modelled as a read followed by a write. It keeps the unlock only when the read is to a protected register and comes immediately after arming. A static lock-enable input, standing in for a configuration fuse, turns the protection off entirely.

A protected write that is dropped sets a sticky status bit, so that software can detect the loss.

Top module: `keyed_write_guard`

## Requirements

The address map used throughout is:

| Address | Register |
|---|---|
| 0 | key |
| 1 | output control (protected) |
| 2 | fault control (protected) |
| 3 | period |
| 4 | phase |
| 5 | status |

Addresses 6 and 7 are unmapped. They read as zero and ignore writes. An access is any cycle with the write strobe or the read strobe high. If both strobes are high, the cycle is treated as a write.

- R1: Writing 0xABCD to address 0 and then 0x4321 to address 0, in two back-to-back accesses, arms the guard. A write to address 1 or 2 as the next access is then stored.
- R2: Once the guard is armed, any other access cancels it, whatever its address, reads included. A protected write that follows the cancelling access is dropped.
- R3: Any access between the first and the second key word returns the guard to idle. A second key word written after that does not arm it.
- R4: One unlock admits exactly one protected write. A second protected write after it is dropped, whether to the same register or the other one, and the register keeps its old value. Two unlock sequences admit two writes.
- R5: When the lock-enable input is 0, writes to addresses 1 and 2 are stored at any time without keys.
- R6: The arming rules for key writes are as follows.
  - A key write of any value other than 0xABCD returns the guard to idle, unless it is 0x4321 directly after 0xABCD.
  - 0x4321 without a preceding 0xABCD does not arm.
  - 0xABCD always restarts the sequence at its first step.
- R7: A read of address 1 or 2 as the access directly after arming keeps the unlock. The following protected write is then stored. A second read, or a read of any other address, cancels the unlock.
- R8: With protection enabled, a dropped write to address 1 or 2 sets bit 0 of the status register (address 5) and the `wr_reject` output. Both stay set until any write to address 5 clears them.
- R9: Address 0 always reads back zero. Addresses 3 and 4 accept writes at any time. Every mapped register reads back its stored value.
- R10: A synchronous reset clears all stored registers and the reject bit, and returns the guard to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_en | input | 1 | 1 enables write protection (static) |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| out_ctrl | output | DW | Protected output-control register |
| flt_ctrl | output | DW | Protected fault-control register |
| period | output | DW | Unprotected period register |
| phase | output | DW | Unprotected phase register |
| wr_reject | output | 1 | Sticky flag for a dropped protected write |

## Verification
The internal sequencer position cannot be seen directly. A wrong sequencer state only shows up at the ports on the next protected write. That write either changes a protected output that should have held, or fails to change it, with `wr_reject` rising in the same cycle.

The bench therefore follows every key pattern, cancelling access and read-before-write case with a protected write. It compares the protected outputs and the reject flag one clock after each access. This exposes a fault in the sequencer no later than the following write.

// File: rtl/keyed_write_guard.sv
module keyed_write_guard #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter logic [DW-1:0] KEY_A = 16'hABCD,
  parameter logic [DW-1:0] KEY_B = 16'h4321,
  parameter logic [AW-1:0] A_KEY  = 3'd0,
  parameter logic [AW-1:0] A_OUT  = 3'd1,
  parameter logic [AW-1:0] A_FLT  = 3'd2,
  parameter logic [AW-1:0] A_PER  = 3'd3,
  parameter logic [AW-1:0] A_PHS  = 3'd4,
  parameter logic [AW-1:0] A_STAT = 3'd5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] out_ctrl,
  output logic [DW-1:0] flt_ctrl,
  output logic [DW-1:0] period,
  output logic [DW-1:0] phase,
  output logic          wr_reject
);
  typedef enum logic [1:0] {S_IDLE, S_HALF, S_ARMED, S_HELD} seq_t;
  seq_t state, nxt;

  wire access  = bus_wr | bus_rd;
  wire is_prot = (bus_addr == A_OUT) || (bus_addr == A_FLT);
  wire open_w  = (state == S_ARMED) || (state == S_HELD);
  wire pwr     = bus_wr && is_prot;
  wire grant   = pwr && (!lock_en || open_w);
  wire reject  = pwr && lock_en && !open_w;
  wire rd_hold = bus_rd && !bus_wr && is_prot && (state == S_ARMED);
  wire key_wr  = bus_wr && (bus_addr == A_KEY);

  always_comb begin
    nxt = state;
    if (access) begin
      if (key_wr) begin
        if (bus_wdata == KEY_A)                         nxt = S_HALF;
        else if (bus_wdata == KEY_B && state == S_HALF) nxt = S_ARMED;
        else                                            nxt = S_IDLE;
      end else if (rd_hold) begin
        nxt = S_HELD;
      end else begin
        nxt = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      out_ctrl  <= '0;
      flt_ctrl  <= '0;
      period    <= '0;
      phase     <= '0;
      wr_reject <= 1'b0;
    end else begin
      state <= nxt;
      if (grant && bus_addr == A_OUT) out_ctrl <= bus_wdata;
      if (grant && bus_addr == A_FLT) flt_ctrl <= bus_wdata;
      if (bus_wr && bus_addr == A_PER) period <= bus_wdata;
      if (bus_wr && bus_addr == A_PHS) phase  <= bus_wdata;
      if (bus_wr && bus_addr == A_STAT) wr_reject <= 1'b0;
      else if (reject)                  wr_reject <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_OUT)  bus_rdata = out_ctrl;
    if (bus_addr == A_FLT)  bus_rdata = flt_ctrl;
    if (bus_addr == A_PER)  bus_rdata = period;
    if (bus_addr == A_PHS)  bus_rdata = phase;
    if (bus_addr == A_STAT) bus_rdata = {{(DW-1){1'b0}}, wr_reject};
  end

  // R1: entering the armed state requires the second key word in the previous cycle
  a_r1_arm_after_key: assert property (@(posedge clk) disable iff (rst)
    (state == S_ARMED && $past(state) != S_ARMED) |->
      $past(bus_wr && bus_addr == A_KEY && bus_wdata == KEY_B));

  // R2: a read of an unprotected address cancels any unlock
  a_r2_read_breaks: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !is_prot) |=> state == S_IDLE);

  // R4: one protected write consumes the unlock
  a_r4_consume: assert property (@(posedge clk) disable iff (rst)
    (pwr && open_w) |=> state == S_IDLE);

  // R4: while locked, the output-control register changes only from an open state
  a_r4_guarded_change: assert property (@(posedge clk) disable iff (rst)
    (lock_en && $past(lock_en) && !$past(rst) && out_ctrl != $past(out_ctrl)) |->
      $past(state == S_ARMED || state == S_HELD));

  // R8: a locked protected write from idle raises the reject flag
  a_r8_flag: assert property (@(posedge clk) disable iff (rst)
    (lock_en && pwr && state == S_IDLE) |=> wr_reject);
endmodule

// File: tb/tb_keyed_write_guard.sv
module tb_keyed_write_guard;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, lock_en = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, out_ctrl, flt_ctrl, period, phase;
  logic        wr_reject;

  keyed_write_guard dut (
    .clk(clk), .rst(rst), .lock_en(lock_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .out_ctrl(out_ctrl), .flt_ctrl(flt_ctrl),
    .period(period), .phase(phase), .wr_reject(wr_reject));

  localparam logic [15:0] K1 = 16'hABCD, K2 = 16'h4321;

  int checks = 0, fails = 0, cyc = 0;

  // Reference model: sequencer position 0 idle, 1 half, 2 armed, 3 armed after a read.
  int m_st = 0;
  logic [15:0] m_oc = '0, m_fc = '0, m_per = '0, m_phs = '0;
  logic m_rej = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] m_read(logic [2:0] a);
    case (a)
      3'd1: return m_oc;
      3'd2: return m_fc;
      3'd3: return m_per;
      3'd4: return m_phs;
      3'd5: return {15'd0, m_rej};
      default: return 16'd0;
    endcase
  endfunction

  task automatic model_step(bit w, bit r, logic [2:0] a, logic [15:0] d);
    bit prot = (a == 3'd1) || (a == 3'd2);
    bit opn = (m_st == 2) || (m_st == 3);
    int ns;
    if (!(w || r)) return;
    if (w && prot) begin
      if (!lock_en || opn) begin
        if (a == 3'd1) m_oc = d; else m_fc = d;
      end else m_rej = 1'b1;
    end
    if (w && a == 3'd3) m_per = d;
    if (w && a == 3'd4) m_phs = d;
    if (w && a == 3'd5) m_rej = 1'b0;
    if (w && a == 3'd0) ns = (d == K1) ? 1 : ((d == K2 && m_st == 1) ? 2 : 0);
    else if (!w && prot && m_st == 2) ns = 3;
    else ns = 0;
    m_st = ns;
  endtask

  task automatic check_regs(string tag);
    chk({tag, " out_ctrl"}, out_ctrl, m_oc);
    chk({tag, " flt_ctrl"}, flt_ctrl, m_fc);
    chk({tag, " period"}, period, m_per);
    chk({tag, " phase"}, phase, m_phs);
    chk({tag, " wr_reject"}, {15'd0, wr_reject}, {15'd0, m_rej});
  endtask

  task automatic acc(bit w, bit r, logic [2:0] a, logic [15:0] d, string tag);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #1;
    if (r && !w) chk({tag, " rdata"}, bus_rdata, m_read(a));
    model_step(w, r, a, d);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check_regs(tag);
  endtask

  task automatic unlock(string tag);
    acc(1, 0, 3'd0, K1, tag);
    acc(1, 0, 3'd0, K2, tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    m_st = 0; m_oc = '0; m_fc = '0; m_per = '0; m_phs = '0; m_rej = 0;
    check_regs(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset("R10 initial reset");

    unlock("R1");
    acc(1, 0, 3'd1, 16'h1234, "R1 out write after unlock");
    unlock("R1");
    acc(1, 0, 3'd2, 16'h00F0, "R1 flt write after unlock");

    unlock("R2");
    acc(1, 0, 3'd3, 16'h0055, "R2 unprotected write");
    acc(1, 0, 3'd1, 16'hDEAD, "R2 cancelled write");
    acc(1, 0, 3'd5, 16'h0000, "R8 status clear");
    unlock("R2");
    acc(0, 1, 3'd6, 16'h0, "R2 unmapped read");
    acc(1, 0, 3'd2, 16'hBEEF, "R2 cancelled by read");

    acc(1, 0, 3'd0, K1, "R3");
    acc(0, 1, 3'd4, 16'h0, "R3 read between keys");
    acc(1, 0, 3'd0, K2, "R3");
    acc(1, 0, 3'd2, 16'h1111, "R3 write rejected");

    acc(1, 0, 3'd0, K2, "R6");
    acc(1, 0, 3'd0, K2, "R6");
    acc(1, 0, 3'd1, 16'h2222, "R6 no partial arm");
    acc(1, 0, 3'd0, K1, "R6");
    acc(1, 0, 3'd0, 16'h1357, "R6 wrong key");
    acc(1, 0, 3'd0, K2, "R6");
    acc(1, 0, 3'd1, 16'h3333, "R6 wrong key dropped write");
    acc(1, 0, 3'd0, K1, "R6");
    acc(1, 0, 3'd0, K1, "R6 restart");
    acc(1, 0, 3'd0, K2, "R6");
    acc(1, 0, 3'd1, 16'h4444, "R6 restart arms");

    unlock("R4");
    acc(1, 0, 3'd1, 16'h5555, "R4 first write");
    acc(1, 0, 3'd1, 16'h6666, "R4 second write ignored");
    unlock("R4");
    acc(1, 0, 3'd1, 16'h7777, "R4 out");
    acc(1, 0, 3'd2, 16'h8888, "R4 flt needs own unlock");
    unlock("R4");
    acc(1, 0, 3'd2, 16'h9999, "R4 second unlock");

    unlock("R7");
    acc(0, 1, 3'd1, 16'h0, "R7 rmw read");
    acc(1, 0, 3'd1, m_oc | 16'h0080, "R7 rmw write");
    unlock("R7");
    acc(0, 1, 3'd2, 16'h0, "R7 read one");
    acc(0, 1, 3'd2, 16'h0, "R7 read two");
    acc(1, 0, 3'd2, 16'h0001, "R7 double read cancels");
    unlock("R7");
    acc(0, 1, 3'd3, 16'h0, "R7 other read");
    acc(1, 0, 3'd1, 16'h0002, "R7 other read cancels");

    acc(0, 1, 3'd5, 16'h0, "R8 status read");
    acc(1, 0, 3'd5, 16'hFFFF, "R8 status clear");

    lock_en = 0;
    acc(1, 0, 3'd1, 16'hA5A5, "R5 unlocked out write");
    acc(1, 0, 3'd2, 16'h5A5A, "R5 unlocked flt write");
    acc(1, 0, 3'd1, 16'h0F0F, "R5 unlocked again");
    lock_en = 1;

    acc(1, 0, 3'd0, K1, "R9");
    acc(0, 1, 3'd0, 16'h0, "R9 key reads zero");
    acc(1, 0, 3'd4, 16'h0C0C, "R9 phase");
    acc(0, 1, 3'd4, 16'h0, "R9 phase readback");
    acc(0, 1, 3'd1, 16'h0, "R9 out readback");

    unlock("R10");
    do_reset("R10 reset clears");
    acc(1, 0, 3'd1, 16'h1111, "R10 reset drops unlock");

    for (int i = 0; i < 4000; i++) begin
      int pick = $urandom_range(0, 99);
      logic [2:0] a = (pick < 40) ? 3'd0 : 3'($urandom_range(0, 7));
      bit w = $urandom_range(0, 2) != 0;
      logic [15:0] d = 16'($urandom);
      if (a == 3'd0) d = (pick < 20) ? K1 : ((pick < 38) ? K2 : d);
      if ((i % 500) == 250) lock_en = ~lock_en;
      acc(w, !w, a, d, "R2 random");
    end
    lock_en = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule